// File: doc/BRIEF.md
# Second-Operand Shifter and Rotated-Immediate Generator

This block builds the second ALU operand for a 32-bit data-processing instruction. It takes the instruction's 12-bit operand field, the flag that selects immediate or register form, the value of the source register and the current carry flag. It returns the 32-bit operand and the carry-out of the shifter. In immediate form, the low byte of the field is rotated right inside a 32-bit word. The rotate distance is twice the 4-bit count held in the upper nibble of the field. In register form, the register value is shifted left or right by a 5-bit constant taken from the field. Vacated bits are filled with zeros.

Work moves through the block as a stream with one register stage. A request carries the field, the flag, the register value and the carry in. It is taken at a rising edge when `in_valid` and `in_ready` are both high. Its result is presented on the following cycle with `out_valid` high. Back-pressure works as follows: the block is ready whenever its output slot is empty or is being drained in the same cycle (`out_ready` high). A result that is not taken stays unchanged on the outputs until it is. The source register index is decoded combinationally, so the register file can be read in the same cycle the request is offered.

Top module: `op2_gen`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_imm`=1, the operand is the zero-extended byte `in_field[7:0]`, rotated right by 2×`in_field[11:8]` positions. For example, byte 0xD9 with count 8 gives 0x00D90000.
- R3: With `in_imm`=1, the carry-out equals `in_carry` when `in_field[11:8]` is 0. Otherwise it equals bit 31 of the rotated operand.
- R4: With `in_imm`=0 and `in_field[5]`=0 (left shift), the operand is `in_rm_val` shifted left by `in_field[11:7]` with zero fill. For example, an amount of 2 yields `in_rm_val`×4 modulo 2^32.
- R5: For a left shift, the carry-out is `in_carry` when the amount is 0. Otherwise it is bit (32 − amount) of `in_rm_val`, the last bit shifted out.
- R6: With `in_imm`=0, `in_field[5]`=1 (right shift) and an amount of 1..31, the operand is `in_rm_val` shifted right with zero fill, which is the unsigned quotient by 2^amount. The carry-out is bit (amount − 1) of `in_rm_val`.
- R7: A right shift with an encoded amount of 0 means a shift by 32. The operand is 0 and the carry-out is bit 31 of `in_rm_val`.
- R8: Field bits 6 and 4 have no effect on the result. In immediate form, `in_rm_val` has no effect on the result.
- R9: A request is taken at an edge where `in_valid` and `in_ready` are both high, and its result is on the outputs with `out_valid`=1 after that edge. `in_ready` equals (not `out_valid`) or `out_ready`.
- R10: While `out_valid`=1 and `out_ready`=0, the next cycle still shows `out_valid`=1 with `out_operand` and `out_carry` unchanged.
- R11: `rm_index` always equals `in_field[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_imm | input | 1 | 1: rotated immediate, 0: shifted register |
| in_field | input | 12 | Operand field of the instruction |
| in_rm_val | input | 32 | Value of the register named by `rm_index` |
| in_carry | input | 1 | Current carry flag |
| rm_index | output | 4 | Source register index decoded from the field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_operand | output | 32 | Second ALU operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Two functions of the output stage can fall in the same cycle: draining the held result and accepting a new request into the same slot. There is also the case where a stalled result must stay frozen while a new request waits. The bench drives the output handshake from a pseudo-random sequence, so drain-and-refill cycles and stall runs of varying length are mixed throughout a sweep of every immediate byte and rotate count and every shift amount and direction. Every result taken is compared in order against an arithmetic model. Every stalled cycle is checked for frozen outputs, and every accepted request must show its result on the very next cycle.

// File: rtl/op2_pkg.sv
package op2_pkg;

  localparam int DATA_W  = 32;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SHAMT_W = 5;
  localparam int IDX_W   = 4;
  localparam int FIELD_W = IMM_W + ROT_W;

  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } sh_kind_e;

  typedef struct packed {
    logic              carry;
    logic [DATA_W-1:0] value;
  } op2_res_t;

endpackage

// File: rtl/op2_rotimm.sv
module op2_rotimm #(
  parameter int XLEN  = op2_pkg::DATA_W,
  parameter int IMM_W = op2_pkg::IMM_W,
  parameter int ROT_W = op2_pkg::ROT_W
) (
  input  logic [IMM_W-1:0] imm_byte,
  input  logic [ROT_W-1:0] rot_cnt,
  input  logic             carry_in,
  output logic [XLEN-1:0]  value,
  output logic             carry_out
);

  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]  distance;
  logic [XLEN-1:0]   widened;
  logic [2*XLEN-1:0] doubled;

  always_comb begin
    distance  = {rot_cnt, 1'b0};
    widened   = XLEN'(imm_byte);
    doubled   = {widened, widened} >> distance;
    value     = doubled[XLEN-1:0];
    carry_out = (rot_cnt == '0) ? carry_in : doubled[XLEN-1];
  end

endmodule

// File: rtl/op2_shift.sv
module op2_shift #(
  parameter int XLEN    = op2_pkg::DATA_W,
  parameter int SHAMT_W = op2_pkg::SHAMT_W
) (
  input  logic [XLEN-1:0]    src,
  input  logic [SHAMT_W-1:0] amount,
  input  op2_pkg::sh_kind_e  kind,
  input  logic               carry_in,
  output logic [XLEN-1:0]    value,
  output logic               carry_out
);

  logic [XLEN:0] left_ext;
  logic [XLEN:0] right_ext;
  logic          amt_zero;

  always_comb begin
    amt_zero  = (amount == '0);
    left_ext  = {1'b0, src} << amount;
    right_ext = {src, 1'b0} >> amount;
    if (kind == op2_pkg::SH_LEFT) begin
      value     = left_ext[XLEN-1:0];
      carry_out = amt_zero ? carry_in : left_ext[XLEN];
    end else if (amt_zero) begin
      value     = '0;
      carry_out = src[XLEN-1];
    end else begin
      value     = right_ext[XLEN:1];
      carry_out = right_ext[0];
    end
  end

endmodule

// File: rtl/op2_stage.sv
module op2_stage #(
  parameter int WIDTH = op2_pkg::DATA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  logic             held;
  logic [WIDTH-1:0] slot;

  assign in_ready  = !held || out_ready;
  assign out_valid = held;
  assign out_data  = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      slot <= '0;
    end else if (in_valid && in_ready) begin
      held <= 1'b1;
      slot <= in_data;
    end else if (out_ready) begin
      held <= 1'b0;
    end
  end

endmodule

// File: rtl/op2_gen.sv
module op2_gen
  import op2_pkg::*;
#(
  parameter int XLEN = op2_pkg::DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_imm,
  input  logic [FIELD_W-1:0] in_field,
  input  logic [XLEN-1:0]    in_rm_val,
  input  logic               in_carry,
  output logic [IDX_W-1:0]   rm_index,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XLEN-1:0]    out_operand,
  output logic               out_carry
);

  localparam int AMT_LSB  = FIELD_W - SHAMT_W;
  localparam int KIND_BIT = AMT_LSB - 2;
  localparam int RES_W    = XLEN + 1;

  logic [SHAMT_W-1:0] sh_amount;
  sh_kind_e           sh_kind;
  logic [XLEN-1:0]    rot_value, shf_value;
  logic               rot_carry, shf_carry;
  logic [RES_W-1:0]   next_res, held_res;
  logic               unused_field_bits;

  assign sh_amount         = in_field[FIELD_W-1 -: SHAMT_W];
  assign sh_kind           = sh_kind_e'(in_field[KIND_BIT]);
  assign rm_index          = in_field[IDX_W-1:0];
  assign unused_field_bits = in_field[AMT_LSB-1] ^ in_field[IDX_W];

  op2_rotimm #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_byte  (in_field[IMM_W-1:0]),
    .rot_cnt   (in_field[FIELD_W-1 -: ROT_W]),
    .carry_in  (in_carry),
    .value     (rot_value),
    .carry_out (rot_carry)
  );

  op2_shift #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_shf (
    .src       (in_rm_val),
    .amount    (sh_amount),
    .kind      (sh_kind),
    .carry_in  (in_carry),
    .value     (shf_value),
    .carry_out (shf_carry)
  );

  assign next_res = in_imm ? {rot_carry, rot_value} : {shf_carry, shf_value};

  op2_stage #(.WIDTH(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (next_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_res)
  );

  assign out_operand = held_res[XLEN-1:0];
  assign out_carry   = held_res[XLEN];

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_operand) && $stable(out_carry));

  assert_rot_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_imm |-> $countones(rot_value) == $countones(in_field[IMM_W-1:0]));

  assert_rot_zero_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_imm && in_field[FIELD_W-1 -: ROT_W] == '0
      |-> rot_carry == in_carry && rot_value == XLEN'(in_field[IMM_W-1:0]));

  assert_left_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_imm && !in_field[KIND_BIT]
      |-> (shf_value & ((XLEN'(1) << sh_amount) - XLEN'(1))) == '0);

  assert_right32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_imm && in_field[KIND_BIT] && sh_amount == '0
      |-> shf_value == '0 && shf_carry == in_rm_val[XLEN-1]);

endmodule

// File: tb/op2_gen_tb.sv
module op2_gen_tb;

  localparam int N_IMM = 4096;
  localparam int N_ALL = N_IMM + 512;

  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, in_imm, in_carry;
  logic [11:0] in_field;
  logic [31:0] in_rm_val;
  logic [3:0]  rm_index;
  logic        out_valid, out_ready, out_carry;
  logic [31:0] out_operand;

  always #4 clk = ~clk;

  op2_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_imm(in_imm), .in_field(in_field), .in_rm_val(in_rm_val),
    .in_carry(in_carry), .rm_index(rm_index), .out_valid(out_valid),
    .out_ready(out_ready), .out_operand(out_operand), .out_carry(out_carry)
  );

  int compared = 0, mismatched = 0;

  logic [31:0] exp_op  [0:N_ALL-1];
  logic        exp_c   [0:N_ALL-1];
  logic [11:0] exp_fld [0:N_ALL-1];
  logic        exp_imm [0:N_ALL-1];
  string       vtag    [0:N_ALL-1];
  string       ctag    [0:N_ALL-1];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pattern(input int p);
    case (p)
      0: return 32'hFFFF_FFFF;
      1: return 32'h8000_0001;
      2: return 32'h1234_5678;
      3: return 32'hDEAD_BEEF;
      4: return 32'h0000_0000;
      5: return 32'h0000_0001;
      6: return 32'h7FFF_FFFF;
      default: return 32'hA5A5_A5A5;
    endcase
  endfunction

  task automatic gen(input int idx, output logic imm, output logic [11:0] f,
                     output logic [31:0] rm, output logic cin);
    if (idx < N_IMM) begin
      imm = 1'b1;
      f   = idx[11:0];
      rm  = 32'(idx) * 32'h9E37_79B9;
      cin = idx[0] ^ idx[5];
    end else begin
      int k;
      k   = idx - N_IMM;
      imm = 1'b0;
      f   = {k[4:0], k[6] ^ k[7], k[5], k[8], k[3:0]};
      rm  = pattern(k / 64);
      cin = k[0] ^ k[2];
    end
  endtask

  task automatic model(input logic imm, input logic [11:0] f, input logic [31:0] rm,
                       input logic cin, output logic [31:0] op, output logic c,
                       output string vt, output string ct);
    if (imm) begin
      int d;
      longint unsigned w;
      d  = 2 * int'(f[11:8]);
      w  = 64'(f[7:0]);
      w  = (w << 32) | w;
      op = 32'(w >> d);
      c  = (d == 0) ? cin : op[31];
      vt = "R2/R8"; ct = "R3";
    end else begin
      int a;
      a = int'(f[11:7]);
      if (!f[5]) begin
        op = rm << a;
        c  = (a == 0) ? cin : rm[32 - a];
        vt = "R4"; ct = "R5";
      end else if (a == 0) begin
        op = 32'h0;
        c  = rm[31];
        vt = "R7"; ct = "R7";
      end else begin
        op = rm / (32'h1 << a);
        c  = rm[a - 1];
        vt = "R6"; ct = "R6";
      end
      if (f[6] || f[4]) vt = {vt, "/R8"};
    end
  endtask

  initial begin
    int idx, head, tail, cyc;
    logic stalled, prev_acc;
    logic [31:0] st_op;
    logic st_c;
    logic [15:0] lfsr;
    logic g_imm, g_cin;
    logic [11:0] g_f;
    logic [31:0] g_rm;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_imm = 1'b0; in_field = '0; in_rm_val = '0; in_carry = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);

    idx = 0; head = 0; tail = 0; cyc = 0;
    stalled = 1'b0; prev_acc = 1'b0; st_op = '0; st_c = 1'b0; lfsr = 16'hACE1;
    while ((idx < N_ALL || head != tail) && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (prev_acc)
        check(out_valid == 1'b1, "R9 result one cycle after accept", 32'(out_valid), 32'h1);
      if (stalled) begin
        check(out_valid == 1'b1, "R10 valid held", 32'(out_valid), 32'h1);
        check(out_operand == st_op, "R10 operand held", out_operand, st_op);
        check(out_carry == st_c, "R10 carry held", 32'(out_carry), 32'(st_c));
      end
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[1];
      if (idx < N_ALL) begin
        gen(idx, g_imm, g_f, g_rm, g_cin);
        in_imm = g_imm; in_field = g_f; in_rm_val = g_rm; in_carry = g_cin;
        in_valid = lfsr[2] | lfsr[3] | lfsr[4];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      check(rm_index == in_field[3:0], "R11 rm_index", 32'(rm_index), 32'(in_field[3:0]));
      check(in_ready == (!out_valid || out_ready), "R9 in_ready rule",
            32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (head == tail) begin
          check(1'b0, "R9 unexpected result", out_operand, 32'h0);
        end else begin
          check(out_operand == exp_op[head], vtag[head], out_operand, exp_op[head]);
          check(out_carry == exp_c[head], ctag[head], 32'(out_carry), 32'(exp_c[head]));
          if (exp_imm[head] && exp_fld[head] == 12'h8D9)
            check(out_operand == 32'h00D9_0000, "R2 byte D9 count 8", out_operand, 32'h00D9_0000);
          head++;
        end
      end
      stalled = out_valid && !out_ready;
      st_op   = out_operand;
      st_c    = out_carry;
      prev_acc = in_valid && in_ready;
      if (prev_acc) begin
        model(g_imm, g_f, g_rm, g_cin, exp_op[tail], exp_c[tail], vtag[tail], ctag[tail]);
        exp_fld[tail] = g_f;
        exp_imm[tail] = g_imm;
        tail++;
        idx++;
      end
    end
    if (cyc >= 60000)
      check(1'b0, "R9 watchdog expired", 32'(head), 32'(N_ALL));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule